// File: doc/BRIEF.md
# Three-Class Nested Interrupt Controller

This block sequences interrupt entry and return for a small processor core. Pending exception events come in as a level vector and each event index belongs to one of three classes: non-critical, critical or debug. When the live machine-state word allows a class, the block takes the winning event. It saves the core's current program counter and machine state into the save/restore pair owned by that class. It then sets the supervisor bit and clears the class's own enable bit together with the enable bits of every lower class. Finally it issues a one-cycle redirect to the handler address. That address joins a software-written 16-bit prefix with a hardwired, 16-byte-aligned offset.

Several event indices share one vector offset, so a syndrome register records which specific event caused each entry. A higher class can preempt a running handler of a lower class, and the lower class's saved context is left untouched. Each class has its own return strobe, which copies the machine state back from that class's pair and redirects fetch to the saved program counter. Debug entries and debug returns only take effect while the debug-enable input is high.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the machine state `msr_o` is 4'b1000, `redirect_vld` is 0, `esr_o` is 0 and the vector prefix is 0. The state bits are [3] supervisor, [2] debug enable, [1] critical enable and [0] non-critical enable.
- R2: Event index i maps to a class: 0..3 non-critical, 4..5 critical, 6..7 debug. A take drives `redirect_vld` high for exactly one cycle, on the clock edge after the event is seen. In that cycle `redirect_pc` = {prefix, 16'h0100 + 16*(i/2)}, so it is 16-byte aligned.
- R3: Among the events that are allowed, debug beats critical and critical beats non-critical. Within a class the lowest index wins. At most one interrupt is taken per cycle.
- R4: A class is taken only while its enable bit is 1: bit 0 for non-critical, bit 1 for critical, and bit 2 for debug.
- R5: On entry, bit 3 is set. The entered class's enable bit and every lower class's enable bit are cleared. Higher enable bits keep their value.
- R6: On every take, `esr_o` is loaded with the event index plus 1. It keeps its value at all other times.
- R7: A take stores `cur_pc` and the pre-entry machine state in that class's pair. The class's return strobe restores `msr_o` from that pair and redirects with `redirect_pc` equal to the saved PC, for one cycle.
- R8: A critical take can preempt a non-critical handler, and a debug take can preempt either. Returning in reverse order restores each level's own PC and machine state.
- R9: While `dbg_en` is 0, debug events are not taken and `ret_dbg` has no effect.
- R10: In a cycle with a valid return strobe, no interrupt is taken. If several return strobes arrive together, the highest class wins.
- R11: `msr_wr` loads `msr_o` from `msr_wdata` when no take or return happens in that cycle. `pfx_wr` loads the prefix used by later takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Enables debug entries, the debug pair and debug return |
| evt_req | input | 8 | Pending exception events, one bit per event index |
| cur_pc | input | 32 | Program counter to save on entry |
| msr_wr | input | 1 | Software write strobe for the machine state |
| msr_wdata | input | 4 | Machine-state write value |
| pfx_wr | input | 1 | Vector prefix write strobe |
| pfx_wdata | input | 16 | Vector prefix write value |
| ret_nc | input | 1 | Return strobe, non-critical class |
| ret_cr | input | 1 | Return strobe, critical class |
| ret_dbg | input | 1 | Return strobe, debug class |
| msr_o | output | 4 | Live machine state |
| redirect_vld | output | 1 | One-cycle fetch redirect valid |
| redirect_pc | output | 32 | Redirect target address |
| esr_o | output | 8 | Syndrome of the last entry |

## Verification
The embedded assertions check these rules on every cycle:
- every entry leaves the supervisor bit set and the non-critical enable clear;
- every redirect is aligned and carries the prefix held in the cycle before;
- a redirect never appears without a take or a return;
- a debug take never happens with `dbg_en` low;
- the winning index always lies inside its class's range;
- a critical take never wins over an allowed debug event;
- a higher-class save never disturbs the non-critical pair.

Other properties are end-to-end and only the bench scenarios can show them:
- the exact vector and syndrome for every index under every event combination;
- the save-and-restore values across a three-deep nest;
- the precedence of returns over takes.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_NC   = 2'd1,
    CLS_CR   = 2'd2,
    CLS_DBG  = 2'd3
  } irq_cls_e;

  typedef struct packed {
    logic sup;
    logic de;
    logic ce;
    logic ee;
  } msr_t;

  localparam int unsigned MSR_W   = 4;
  localparam int unsigned N_CLS   = 3;
  localparam int unsigned CLS_SEL = 2;

  localparam msr_t MSR_RESET = '{sup: 1'b1, de: 1'b0, ce: 1'b0, ee: 1'b0};

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_nest_pkg::*; #(
  parameter int unsigned N_NC  = 4,
  parameter int unsigned N_CR  = 2,
  parameter int unsigned N_DBG = 2,
  parameter int unsigned N_EVT = N_NC + N_CR + N_DBG,
  parameter int unsigned IDX_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_req,
  input  msr_t             msr_i,
  input  logic             dbg_en,
  input  logic             hold,
  output irq_cls_e         take_cls,
  output logic [IDX_W-1:0] take_idx
);

  localparam int unsigned LO_NC  = 0;
  localparam int unsigned LO_CR  = N_NC;
  localparam int unsigned LO_DBG = N_NC + N_CR;

  // Returns {found, index} for the lowest set bit in [lo, lo+cnt).
  function automatic logic [IDX_W:0] pick_low(
    input logic [N_EVT-1:0] vec,
    input int unsigned      lo,
    input int unsigned      cnt
  );
    logic [IDX_W:0] res;
    res = '0;
    for (int k = int'(lo + cnt) - 1; k >= int'(lo); k--) begin
      if (vec[k]) res = {1'b1, IDX_W'(k)};
    end
    return res;
  endfunction

  logic [IDX_W:0] sel_nc, sel_cr, sel_dbg;
  logic           ok_nc, ok_cr, ok_dbg;

  always_comb begin
    sel_nc  = pick_low(evt_req, LO_NC,  N_NC);
    sel_cr  = pick_low(evt_req, LO_CR,  N_CR);
    sel_dbg = pick_low(evt_req, LO_DBG, N_DBG);
    ok_dbg  = sel_dbg[IDX_W] & dbg_en & msr_i.de;
    ok_cr   = sel_cr[IDX_W]  & msr_i.ce;
    ok_nc   = sel_nc[IDX_W]  & msr_i.ee;
  end

  always_comb begin
    take_cls = CLS_NONE;
    take_idx = '0;
    if (!hold) begin
      if (ok_dbg) begin
        take_cls = CLS_DBG;
        take_idx = sel_dbg[IDX_W-1:0];
      end else if (ok_cr) begin
        take_cls = CLS_CR;
        take_idx = sel_cr[IDX_W-1:0];
      end else if (ok_nc) begin
        take_cls = CLS_NC;
        take_idx = sel_nc[IDX_W-1:0];
      end
    end
  end

  AST_IDX_IN_NC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cls == CLS_NC) |-> (int'(take_idx) < int'(LO_CR))); // R2
  AST_IDX_IN_CR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cls == CLS_CR) |-> (int'(take_idx) >= int'(LO_CR) && int'(take_idx) < int'(LO_DBG))); // R2
  AST_CR_NOT_OVER_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cls == CLS_CR) |-> !(dbg_en && msr_i.de && (|evt_req[N_EVT-1:LO_DBG]))); // R3
  AST_NC_NEEDS_EE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cls == CLS_NC) |-> msr_i.ee); // R4
  AST_HOLD_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (take_cls == CLS_NONE)); // R10

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PFX_W    = 16,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned SYN_W    = 8,
  parameter int unsigned VEC_SH   = 1,
  parameter int unsigned ALIGN_SH = 4,
  parameter int unsigned OFS_BASE = 256
) (
  input  logic [PFX_W-1:0] prefix,
  input  logic [IDX_W-1:0] idx,
  output logic [PC_W-1:0]  target,
  output logic [SYN_W-1:0] syndrome
);

  localparam int unsigned OFS_W = PC_W - PFX_W;

  logic [IDX_W-1:0] slot;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    slot     = idx >> VEC_SH;
    ofs      = OFS_W'(OFS_BASE) + (OFS_W'(slot) << ALIGN_SH);
    target   = {prefix, ofs};
    syndrome = SYN_W'(idx) + SYN_W'(1);
  end

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank import irq_nest_pkg::*; #(
  parameter int unsigned PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLS-1:0]   wr_en,
  input  logic [PC_W-1:0]    wr_pc,
  input  msr_t               wr_msr,
  input  logic [CLS_SEL-1:0] rd_sel,
  output logic [PC_W-1:0]    rd_pc,
  output msr_t               rd_msr
);

  logic [PC_W-1:0] pc_q  [N_CLS];
  logic [PC_W-1:0] pc_d  [N_CLS];
  msr_t            msr_q [N_CLS];
  msr_t            msr_d [N_CLS];

  for (genvar g = 0; g < N_CLS; g++) begin : g_pair
    always_comb begin
      pc_d[g]  = pc_q[g];
      msr_d[g] = msr_q[g];
      if (wr_en[g]) begin
        pc_d[g]  = wr_pc;
        msr_d[g] = wr_msr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[g]  <= '0;
        msr_q[g] <= '0;
      end else if (wr_en[g]) begin
        pc_q[g]  <= pc_d[g];
        msr_q[g] <= msr_d[g];
      end
    end
  end

  always_comb begin
    rd_pc  = '0;
    rd_msr = '0;
    for (int k = 0; k < int'(N_CLS); k++) begin
      if (rd_sel == CLS_SEL'(k)) begin
        rd_pc  = pc_q[k];
        rd_msr = msr_q[k];
      end
    end
  end

  AST_ONE_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R3
  AST_NC_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[1] || wr_en[2]) |=> ($stable(pc_q[0]) && $stable(msr_q[0]))); // R8

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl import irq_nest_pkg::*; #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PFX_W    = 16,
  parameter int unsigned N_NC     = 4,
  parameter int unsigned N_CR     = 2,
  parameter int unsigned N_DBG    = 2,
  parameter int unsigned SYN_W    = 8,
  parameter int unsigned VEC_SH   = 1,
  parameter int unsigned ALIGN_SH = 4,
  parameter int unsigned OFS_BASE = 256,
  parameter int unsigned N_EVT    = N_NC + N_CR + N_DBG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_en,
  input  logic [N_EVT-1:0] evt_req,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             msr_wr,
  input  logic [MSR_W-1:0] msr_wdata,
  input  logic             pfx_wr,
  input  logic [PFX_W-1:0] pfx_wdata,
  input  logic             ret_nc,
  input  logic             ret_cr,
  input  logic             ret_dbg,
  output logic [MSR_W-1:0] msr_o,
  output logic             redirect_vld,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [SYN_W-1:0] esr_o
);

  localparam int unsigned IDX_W = $clog2(N_EVT);

  msr_t             msr_q, msr_d;
  logic [PFX_W-1:0] pfx_q, pfx_d;
  logic [SYN_W-1:0] esr_q, esr_d;
  logic [PC_W-1:0]  rpc_q, rpc_d;
  logic             rvld_q, rvld_d;
  logic             msr_en, esr_en, rpc_en;

  logic               ret_dbg_v, ret_any;
  logic [CLS_SEL-1:0] ret_sel;
  irq_cls_e           take_cls;
  logic [IDX_W-1:0]   take_idx;
  logic               take;
  logic [N_CLS-1:0]   save_en;
  logic [PC_W-1:0]    vec_target, sv_pc;
  logic [SYN_W-1:0]   vec_syn;
  msr_t               sv_msr;

  // Return selection: highest class strobe wins.
  always_comb begin
    ret_dbg_v = ret_dbg & dbg_en;
    ret_any   = ret_dbg_v | ret_cr | ret_nc;
    if (ret_dbg_v)   ret_sel = CLS_SEL'(2);
    else if (ret_cr) ret_sel = CLS_SEL'(1);
    else             ret_sel = CLS_SEL'(0);
  end

  irq_arbiter #(
    .N_NC (N_NC),
    .N_CR (N_CR),
    .N_DBG(N_DBG)
  ) arb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_req (evt_req),
    .msr_i   (msr_q),
    .dbg_en  (dbg_en),
    .hold    (ret_any),
    .take_cls(take_cls),
    .take_idx(take_idx)
  );

  irq_vec_gen #(
    .PC_W    (PC_W),
    .PFX_W   (PFX_W),
    .IDX_W   (IDX_W),
    .SYN_W   (SYN_W),
    .VEC_SH  (VEC_SH),
    .ALIGN_SH(ALIGN_SH),
    .OFS_BASE(OFS_BASE)
  ) vec_i (
    .prefix  (pfx_q),
    .idx     (take_idx),
    .target  (vec_target),
    .syndrome(vec_syn)
  );

  always_comb begin
    take       = (take_cls != CLS_NONE);
    save_en[0] = (take_cls == CLS_NC);
    save_en[1] = (take_cls == CLS_CR);
    save_en[2] = (take_cls == CLS_DBG);
  end

  irq_save_bank #(
    .PC_W(PC_W)
  ) bank_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (save_en),
    .wr_pc (cur_pc),
    .wr_msr(msr_q),
    .rd_sel(ret_sel),
    .rd_pc (sv_pc),
    .rd_msr(sv_msr)
  );

  // Next-state logic
  always_comb begin
    msr_d  = msr_q;
    esr_d  = esr_q;
    rpc_d  = rpc_q;
    rvld_d = 1'b0;
    pfx_d  = pfx_wdata;
    msr_en = 1'b0;
    esr_en = 1'b0;
    rpc_en = 1'b0;
    if (ret_any) begin
      msr_d  = sv_msr;
      rpc_d  = sv_pc;
      rvld_d = 1'b1;
      msr_en = 1'b1;
      rpc_en = 1'b1;
    end else if (take) begin
      msr_d.sup = 1'b1;
      msr_d.ee  = 1'b0;
      if (take_cls == CLS_CR || take_cls == CLS_DBG) msr_d.ce = 1'b0;
      if (take_cls == CLS_DBG)                       msr_d.de = 1'b0;
      rpc_d  = vec_target;
      esr_d  = vec_syn;
      rvld_d = 1'b1;
      msr_en = 1'b1;
      esr_en = 1'b1;
      rpc_en = 1'b1;
    end else if (msr_wr) begin
      msr_d  = msr_t'(msr_wdata);
      msr_en = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_q  <= MSR_RESET;
      pfx_q  <= '0;
      esr_q  <= '0;
      rpc_q  <= '0;
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= rvld_d;
      if (msr_en) msr_q <= msr_d;
      if (pfx_wr) pfx_q <= pfx_d;
      if (esr_en) esr_q <= esr_d;
      if (rpc_en) rpc_q <= rpc_d;
    end
  end

  always_comb begin
    msr_o        = msr_q;
    redirect_vld = rvld_q;
    redirect_pc  = rpc_q;
    esr_o        = esr_q;
  end

  AST_SUP_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> msr_o[3]); // R5
  AST_EE_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !msr_o[0]); // R5
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (redirect_vld && redirect_pc[ALIGN_SH-1:0] == '0)); // R2
  AST_VEC_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (redirect_pc[PC_W-1 -: PFX_W] == $past(pfx_q))); // R2
  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !ret_any) |=> !redirect_vld); // R2
  AST_DBG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |-> (take_cls != CLS_DBG)); // R9

endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_en;
  logic [7:0]  evt_req;
  logic [31:0] cur_pc;
  logic        msr_wr;
  logic [3:0]  msr_wdata;
  logic        pfx_wr;
  logic [15:0] pfx_wdata;
  logic        ret_nc, ret_cr, ret_dbg;
  logic [3:0]  msr_o;
  logic        redirect_vld;
  logic [31:0] redirect_pc;
  logic [7:0]  esr_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] pfx_m;

  always #5 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .evt_req(evt_req), .cur_pc(cur_pc),
    .msr_wr(msr_wr), .msr_wdata(msr_wdata), .pfx_wr(pfx_wr), .pfx_wdata(pfx_wdata),
    .ret_nc(ret_nc), .ret_cr(ret_cr), .ret_dbg(ret_dbg),
    .msr_o(msr_o), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .esr_o(esr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int cls_of(input int i);
    if (i < 4) return 0;
    if (i < 6) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] vec_of(input logic [15:0] p, input int i);
    return {p, 16'(256 + 16 * (i / 2))};
  endfunction

  function automatic logic [3:0] entry_msr(input int c, input logic [3:0] m);
    logic [3:0] keep;
    keep = (c == 0) ? 4'b0110 : (c == 1) ? 4'b0100 : 4'b0000;
    return (m & keep) | 4'b1000;
  endfunction

  function automatic int winner(input logic [7:0] p);
    if (p[6]) return 6;
    if (p[7]) return 7;
    if (p[4]) return 4;
    if (p[5]) return 5;
    for (int k = 0; k < 4; k++) if (p[k]) return k;
    return -1;
  endfunction

  task automatic set_msr(input logic [3:0] v);
    msr_wr = 1'b1; msr_wdata = v;
    step();
    msr_wr = 1'b0;
  endtask

  task automatic set_pfx(input logic [15:0] v);
    pfx_wr = 1'b1; pfx_wdata = v;
    step();
    pfx_wr = 1'b0;
    pfx_m = v;
  endtask

  task automatic fire(input logic [7:0] ev, input logic [31:0] pc);
    evt_req = ev; cur_pc = pc;
    step();
    evt_req = '0;
  endtask

  task automatic do_ret(input int c);
    ret_nc = (c == 0); ret_cr = (c == 1); ret_dbg = (c == 2);
    step();
    ret_nc = 1'b0; ret_cr = 1'b0; ret_dbg = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dbg_en = 1'b1; evt_req = '0; cur_pc = '0;
    msr_wr = 1'b0; msr_wdata = '0; pfx_wr = 1'b0; pfx_wdata = '0;
    ret_nc = 1'b0; ret_cr = 1'b0; ret_dbg = 1'b0; pfx_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 msr", 32'(msr_o), 32'h8);
    chk("R1 vld", 32'(redirect_vld), 32'h0);
    chk("R1 esr", 32'(esr_o), 32'h0);
    // R1 prefix zero after reset, seen at first take
    set_msr(4'hF);
    chk("R11 msr write", 32'(msr_o), 32'hF);
    fire(8'h01, 32'h100);
    chk("R1 reset prefix", redirect_pc, vec_of(16'h0, 0));
    do_ret(0);

    // Single-event sweep over all indices
    for (int i = 0; i < 8; i++) begin
      set_pfx(16'h1000 + 16'(i * 16'h0111));
      set_msr(4'hF);
      fire(8'(1 << i), 32'h4000 + 32'(i * 4));
      chk("R2 vld", 32'(redirect_vld), 32'h1);
      chk("R2 vector", redirect_pc, vec_of(pfx_m, i));
      chk("R6 syndrome", 32'(esr_o), 32'(i + 1));
      chk("R5 entry msr", 32'(msr_o), 32'(entry_msr(cls_of(i), 4'hF)));
      step();
      chk("R2 one cycle", 32'(redirect_vld), 32'h0);
      chk("R6 esr held", 32'(esr_o), 32'(i + 1));
      do_ret(cls_of(i));
      chk("R7 ret pc", redirect_pc, 32'h4000 + 32'(i * 4));
      chk("R7 ret msr", 32'(msr_o), 32'hF);
    end

    // Priority sweep over every event combination
    set_pfx(16'hA5C0);
    for (int p = 1; p < 256; p++) begin
      set_msr(4'hF);
      fire(8'(p), 32'h8000 + 32'(p));
      chk("R3 winner vector", redirect_pc, vec_of(pfx_m, winner(8'(p))));
      chk("R3 winner esr", 32'(esr_o), 32'(winner(8'(p)) + 1));
      do_ret(cls_of(winner(8'(p))));
      chk("R7 sweep ret", redirect_pc, 32'h8000 + 32'(p));
    end

    // Enable gating per class
    set_msr(4'b1110);
    fire(8'h01, 32'h1);
    chk("R4 ee off", 32'(redirect_vld), 32'h0);
    chk("R4 msr kept", 32'(msr_o), 32'hE);
    set_msr(4'b1101);
    fire(8'h10, 32'h2);
    chk("R4 ce off", 32'(redirect_vld), 32'h0);
    set_msr(4'b1011);
    fire(8'h40, 32'h3);
    chk("R4 de off", 32'(redirect_vld), 32'h0);

    // Debug gating
    dbg_en = 1'b0;
    set_msr(4'hF);
    fire(8'h80, 32'h4);
    chk("R9 dbg event ignored", 32'(redirect_vld), 32'h0);
    fire(8'hC0 | 8'h20, 32'h5);
    chk("R9 critical wins", redirect_pc, vec_of(pfx_m, 5));
    do_ret(2);
    chk("R9 ret_dbg ignored", 32'(redirect_vld), 32'h0);
    chk("R9 msr unchanged", 32'(msr_o), 32'hC);
    do_ret(1);
    dbg_en = 1'b1;

    // Three-deep nesting
    set_msr(4'hF);
    fire(8'h02, 32'hAAA0);
    chk("R8 nc entry", 32'(msr_o), 32'hE);
    fire(8'h04, 32'hDEAD);
    chk("R5 same class blocked", 32'(redirect_vld), 32'h0);
    fire(8'h20, 32'hBBB0);
    chk("R8 cr preempts", redirect_pc, vec_of(pfx_m, 5));
    chk("R8 cr msr", 32'(msr_o), 32'hC);
    fire(8'h80, 32'hCCC0);
    chk("R8 dbg preempts", redirect_pc, vec_of(pfx_m, 7));
    chk("R8 dbg msr", 32'(msr_o), 32'h8);
    do_ret(2);
    chk("R8 dbg ret pc", redirect_pc, 32'hCCC0);
    chk("R8 dbg ret msr", 32'(msr_o), 32'hC);
    do_ret(1);
    chk("R8 cr ret pc", redirect_pc, 32'hBBB0);
    chk("R8 cr ret msr", 32'(msr_o), 32'hE);
    do_ret(0);
    chk("R8 nc ret pc", redirect_pc, 32'hAAA0);
    chk("R8 nc ret msr", 32'(msr_o), 32'hF);

    // Return beats take; highest return wins
    evt_req = 8'h01; ret_nc = 1'b1; cur_pc = 32'h9999;
    step();
    evt_req = '0; ret_nc = 1'b0;
    chk("R10 ret wins pc", redirect_pc, 32'hAAA0);
    chk("R10 esr unchanged", 32'(esr_o), 32'h8);
    ret_nc = 1'b1; ret_cr = 1'b1;
    step();
    ret_nc = 1'b0; ret_cr = 1'b0;
    chk("R10 highest ret pc", redirect_pc, 32'hBBB0);
    chk("R10 highest ret msr", 32'(msr_o), 32'hE);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule